// File: doc/BRIEF.md
# Accumulator Puzzle CPU

An 8-bit multicycle processor with a single working register (the accumulator), a 32-byte data RAM and a separate program store. Values enter through an input queue handshake and leave through an output queue handshake; an instruction that finds its queue unable to serve it simply stalls in place. Each instruction is an opcode byte, optionally followed by an operand byte. A control state machine fetches the opcode, fetches the operand when there is one, resolves one level of indirection when bit 3 of a memory opcode is set, and then executes.

The program store is written through a simple load port, normally while reset is held, and is read by the fetch logic afterwards. A single-step mode holds the machine just before each opcode fetch until a step pulse arrives, so a debugger can examine state between instructions. The HALT instruction parks the machine permanently.

Top module: `acc8_cpu`

## Requirements
- R1: After reset the program counter is 0x00, halted_o is low, no pop or push is issued, the accumulator is zero and every RAM cell reads zero.
- R2: The upper opcode nibble selects the operation; INBOX (0x0_), OUTBOX (0x1_), HALT (0xF_) and the unused nibbles 0xB, 0xD and 0xE are one byte long, every other opcode takes one operand byte. The unused nibbles execute as no-ops.
- R3: INBOX (0x00) waits while in_valid_i is low; when it is high it asserts in_pop_o for exactly that cycle and loads in_data_i into the accumulator.
- R4: OUTBOX (0x10) waits while out_full_i is high; otherwise it asserts out_push_o for one cycle with out_data_o equal to the accumulator.
- R5: COPYFROM (0x20) loads the accumulator from RAM, COPYTO (0x30) stores it to RAM, SET (0xC0) loads the operand byte itself into the accumulator.
- R6: ADD (0x40) and SUB (0x50) replace the accumulator with accumulator plus or minus the RAM value, modulo 256.
- R7: BUMP+ (0x60) and BUMP- (0x70) add or subtract one on the RAM value and write the result both to RAM and to the accumulator.
- R8: The low 5 bits of the operand address RAM. For opcodes 0x2_ to 0x7_ with bit 3 set (e.g. 0x28), the low 5 bits of the addressed cell become the effective address.
- R9: JUMP (0x80) always loads the operand into the program counter; JUMPZ (0x90) does so only if the accumulator is zero and JUMPN (0xA0) only if accumulator bit 7 is set; otherwise execution falls through.
- R10: After HALT (0xF0) halted_o stays high and the program counter, RAM and queues are left untouched until reset.
- R11: With debug_i high the machine waits before each opcode fetch and performs exactly one instruction per step_i pulse; a pulse given while an instruction is in progress is remembered for the next fetch.
- R12: Without stalls an instruction takes 2 cycles if one byte long, 3 if two bytes long and 4 if it is indirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Program store write enable |
| prog_addr_i | input | 8 | Program store write address |
| prog_data_i | input | 8 | Program store write data |
| debug_i | input | 1 | Single-step mode enable |
| step_i | input | 1 | Step request pulse |
| in_valid_i | input | 1 | Input queue holds an element |
| in_data_i | input | 8 | Head of the input queue |
| in_pop_o | output | 1 | Consume the input queue head |
| out_full_i | input | 1 | Output queue cannot accept |
| out_push_o | output | 1 | Write out_data_o to the output queue |
| out_data_o | output | 8 | Accumulator value for the output queue |
| pc_o | output | 8 | Program counter |
| halted_o | output | 1 | Machine has executed HALT |

## Verification
Queue results appear on the cycle the execute state is entered and are sampled at the falling edge of that same cycle, so each pop and push is counted exactly once. Total cycle counts are compared with a per-instruction sum of 2, 3 or 4 cycles computed from the program by an instruction-level model in the bench, counted from reset release to the first cycle halted_o reads high. Program counter values in stall, single-step and halt scenarios are read one full instruction time after the stimulus, once the machine has settled in its waiting state.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  localparam logic [3:0] OP_INBOX    = 4'h0;
  localparam logic [3:0] OP_OUTBOX   = 4'h1;
  localparam logic [3:0] OP_COPYFROM = 4'h2;
  localparam logic [3:0] OP_COPYTO   = 4'h3;
  localparam logic [3:0] OP_ADD      = 4'h4;
  localparam logic [3:0] OP_SUB      = 4'h5;
  localparam logic [3:0] OP_BUMPUP   = 4'h6;
  localparam logic [3:0] OP_BUMPDN   = 4'h7;
  localparam logic [3:0] OP_JUMP     = 4'h8;
  localparam logic [3:0] OP_JUMPZ    = 4'h9;
  localparam logic [3:0] OP_JUMPN    = 4'hA;
  localparam logic [3:0] OP_SET      = 4'hC;
  localparam logic [3:0] OP_HALT     = 4'hF;

  typedef enum logic [2:0] {ST_FETCH, ST_OPND, ST_IND, ST_EXEC, ST_HALT} state_e;
  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_INC, ALU_DEC} alu_op_e;
  typedef enum logic [1:0] {ACC_ALU, ACC_MEM, ACC_IN, ACC_IMM} acc_sel_e;

  typedef struct packed {
    logic     ir_ld;
    logic     opnd_ld;
    logic     pc_inc;
    logic     ea_ind;
    logic     acc_we;
    logic     ram_we;
    logic     ram_from_alu;
    logic     branch;
    logic     ijump;
    logic     cmp_neg;
    logic     pop;
    logic     push;
    alu_op_e  alu_op;
    acc_sel_e acc_sel;
  } ctrl_t;

  function automatic logic has_operand(input logic [3:0] op);
    return !(op inside {OP_INBOX, OP_OUTBOX, OP_HALT, 4'hB, 4'hD, 4'hE});
  endfunction

  function automatic logic mem_op(input logic [3:0] op);
    return op inside {[OP_COPYFROM:OP_BUMPDN]};
  endfunction

endpackage

// File: rtl/acc8_alu.sv
module acc8_alu import acc8_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mem_i,
  input  alu_op_e      op_i,
  input  logic         cmp_neg_i,
  output logic [W-1:0] res_o,
  output logic         flag_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: res_o = acc_i + mem_i;
      ALU_SUB: res_o = acc_i - mem_i;
      ALU_INC: res_o = mem_i + 1'b1;
      default: res_o = mem_i - 1'b1;
    endcase
  end

  assign flag_o = cmp_neg_i ? acc_i[W-1] : (acc_i == '0);
endmodule

// File: rtl/acc8_ram.sv
module acc8_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/acc8_ctrl.sv
module acc8_ctrl import acc8_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       debug_i,
  input  logic       step_i,
  input  logic [3:0] fetch_op_i,
  input  logic [3:0] ir_op_i,
  input  logic       ir_ind_i,
  input  logic       in_valid_i,
  input  logic       out_full_i,
  output ctrl_t      ctl_o,
  output state_e     state_o,
  output logic       step_arm_o
);
  state_e state_q, state_d;
  ctrl_t  ctl;
  logic   arm_q, go, consume, ind;

  assign go  = arm_q | step_i;
  assign ind = ir_ind_i & mem_op(ir_op_i);

  always_comb begin
    ctl.ir_ld = 1'b0;       ctl.opnd_ld = 1'b0;  ctl.pc_inc = 1'b0;
    ctl.ea_ind = 1'b0;      ctl.acc_we = 1'b0;   ctl.ram_we = 1'b0;
    ctl.ram_from_alu = 1'b0; ctl.branch = 1'b0;  ctl.ijump = 1'b0;
    ctl.cmp_neg = 1'b0;     ctl.pop = 1'b0;      ctl.push = 1'b0;
    ctl.alu_op = ALU_ADD;   ctl.acc_sel = ACC_ALU;
    consume = 1'b0;
    state_d = state_q;
    case (state_q)
      ST_FETCH: begin
        // debug mode parks here until a step is pending
        if (!debug_i || go) begin
          ctl.ir_ld  = 1'b1;
          ctl.pc_inc = 1'b1;
          consume    = debug_i;
          state_d    = has_operand(fetch_op_i) ? ST_OPND : ST_EXEC;
        end
      end
      ST_OPND: begin
        ctl.opnd_ld = 1'b1;
        ctl.pc_inc  = 1'b1;
        state_d     = ind ? ST_IND : ST_EXEC;
      end
      ST_IND: begin
        ctl.ea_ind = 1'b1;
        state_d    = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        case (ir_op_i)
          OP_INBOX: begin
            if (in_valid_i) begin
              ctl.pop = 1'b1; ctl.acc_we = 1'b1; ctl.acc_sel = ACC_IN;
            end else begin
              state_d = ST_EXEC;
            end
          end
          OP_OUTBOX: begin
            if (!out_full_i) ctl.push = 1'b1;
            else             state_d = ST_EXEC;
          end
          OP_COPYFROM: begin ctl.acc_we = 1'b1; ctl.acc_sel = ACC_MEM; end
          OP_COPYTO:   ctl.ram_we = 1'b1;
          OP_ADD:      begin ctl.acc_we = 1'b1; ctl.alu_op = ALU_ADD; end
          OP_SUB:      begin ctl.acc_we = 1'b1; ctl.alu_op = ALU_SUB; end
          OP_BUMPUP: begin
            ctl.alu_op = ALU_INC; ctl.acc_we = 1'b1;
            ctl.ram_we = 1'b1;    ctl.ram_from_alu = 1'b1;
          end
          OP_BUMPDN: begin
            ctl.alu_op = ALU_DEC; ctl.acc_we = 1'b1;
            ctl.ram_we = 1'b1;    ctl.ram_from_alu = 1'b1;
          end
          OP_JUMP:  begin ctl.branch = 1'b1; ctl.ijump = 1'b1; end
          OP_JUMPZ: ctl.branch = 1'b1;
          OP_JUMPN: begin ctl.branch = 1'b1; ctl.cmp_neg = 1'b1; end
          OP_SET:   begin ctl.acc_we = 1'b1; ctl.acc_sel = ACC_IMM; end
          OP_HALT:  state_d = ST_HALT;
          default: ;
        endcase
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      arm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      arm_q   <= debug_i & (arm_q | step_i) & ~consume;
    end
  end

  assign ctl_o      = ctl;
  assign state_o    = state_q;
  assign step_arm_o = arm_q;
endmodule

// File: rtl/acc8_cpu.sv
module acc8_cpu import acc8_pkg::*; #(
  parameter int  DATA_W     = 8,
  parameter int  RAM_DEPTH  = 32,
  parameter int  PROG_DEPTH = 256,
  localparam int PC_W       = $clog2(PROG_DEPTH),
  localparam int ADDR_W     = $clog2(RAM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_we_i,
  input  logic [PC_W-1:0]   prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  input  logic              debug_i,
  input  logic              step_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_pop_o,
  input  logic              out_full_i,
  output logic              out_push_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              halted_o
);
  logic [DATA_W-1:0] rom [PROG_DEPTH];
  logic [DATA_W-1:0] fetch_word, opnd_q, acc_q, acc_nxt, ram_rd, ram_wd, alu_res;
  logic [PC_W-1:0]   pc_q;
  logic [4:0]        ir_q;   // opcode nibble + indirect bit
  logic [ADDR_W-1:0] ea_q;
  logic              alu_flag, taken, step_arm;
  ctrl_t             ctl;
  state_e            state;

  always_ff @(posedge clk_i) begin
    if (prog_we_i) rom[prog_addr_i] <= prog_data_i;
  end

  assign fetch_word = rom[pc_q];

  acc8_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .debug_i    (debug_i),
    .step_i     (step_i),
    .fetch_op_i (fetch_word[DATA_W-1 -: 4]),
    .ir_op_i    (ir_q[4:1]),
    .ir_ind_i   (ir_q[0]),
    .in_valid_i (in_valid_i),
    .out_full_i (out_full_i),
    .ctl_o      (ctl),
    .state_o    (state),
    .step_arm_o (step_arm)
  );

  acc8_alu #(.W(DATA_W)) u_alu (
    .acc_i     (acc_q),
    .mem_i     (ram_rd),
    .op_i      (ctl.alu_op),
    .cmp_neg_i (ctl.cmp_neg),
    .res_o     (alu_res),
    .flag_o    (alu_flag)
  );

  assign ram_wd = ctl.ram_from_alu ? alu_res : acc_q;

  acc8_ram #(.W(DATA_W), .DEPTH(RAM_DEPTH)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl.ram_we),
    .addr_i  (ea_q),
    .wdata_i (ram_wd),
    .rdata_o (ram_rd)
  );

  assign taken = ctl.branch & (ctl.ijump | alu_flag);

  always_comb begin
    case (ctl.acc_sel)
      ACC_MEM: acc_nxt = ram_rd;
      ACC_IN:  acc_nxt = in_data_i;
      ACC_IMM: acc_nxt = opnd_q;
      default: acc_nxt = alu_res;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      ir_q   <= '0;
      opnd_q <= '0;
      ea_q   <= '0;
      acc_q  <= '0;
    end else begin
      if (ctl.ir_ld) ir_q <= fetch_word[DATA_W-1 -: 5];
      if (ctl.opnd_ld) begin
        opnd_q <= fetch_word;
        ea_q   <= fetch_word[ADDR_W-1:0];
      end else if (ctl.ea_ind) begin
        ea_q   <= ram_rd[ADDR_W-1:0];
      end
      if (taken)           pc_q <= opnd_q[PC_W-1:0];
      else if (ctl.pc_inc) pc_q <= pc_q + 1'b1;
      if (ctl.acc_we) acc_q <= acc_nxt;
    end
  end

  assign in_pop_o   = ctl.pop;
  assign out_push_o = ctl.push;
  assign out_data_o = acc_q;
  assign pc_o       = pc_q;
  assign halted_o   = (state == ST_HALT);
endmodule

// File: rtl/acc8_cpu_chk.sv
module acc8_cpu_chk import acc8_pkg::*; #(
  parameter int PC_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            debug_i,
  input logic            step_i,
  input logic            in_valid_i,
  input logic            in_pop_o,
  input logic            out_full_i,
  input logic            out_push_o,
  input logic            halted_o,
  input logic [PC_W-1:0] pc_o,
  input state_e          state_i,
  input logic            arm_i
);
  AST_POP_WITH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pop_o |-> in_valid_i); // R3

  AST_SINGLE_QUEUE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_pop_o && out_push_o)); // R3

  AST_PUSH_WITH_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_push_o |-> !out_full_i); // R4

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_o))); // R10

  AST_DEBUG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH && debug_i && !arm_i && !step_i) |=> $stable(pc_o)); // R11

  AST_FETCH_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH && !debug_i) |=> (pc_o == PC_W'($past(pc_o) + 1'b1))); // R12
endmodule

bind acc8_cpu acc8_cpu_chk #(.PC_W(PC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .debug_i    (debug_i),
  .step_i     (step_i),
  .in_valid_i (in_valid_i),
  .in_pop_o   (in_pop_o),
  .out_full_i (out_full_i),
  .out_push_o (out_push_o),
  .halted_o   (halted_o),
  .pc_o       (pc_o),
  .state_i    (state),
  .arm_i      (step_arm)
);

// File: tb/acc8_cpu_test.sv
module acc8_cpu_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       prog_we_i = 1'b0;
  logic [7:0] prog_addr_i = '0;
  logic [7:0] prog_data_i = '0;
  logic       debug_i = 1'b0;
  logic       step_i = 1'b0;
  logic       in_valid_i;
  logic [7:0] in_data_i;
  logic       in_pop_o;
  logic       out_full_i;
  logic       out_push_o;
  logic [7:0] out_data_o;
  logic [7:0] pc_o;
  logic       halted_o;

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] prog [256];
  int pl;
  logic [7:0] inq [64];
  int in_n = 0, ip = 0;
  logic [7:0] outq [64];
  int on = 0;
  logic [7:0] expq [64];
  int en, ref_cyc;
  bit ref_halt;
  bit avail = 1'b0, full_q = 1'b0, rand_stall = 1'b0;
  int pop_cnt = 0, push_cnt = 0;

  assign in_valid_i = avail && (ip < in_n);
  assign in_data_i  = inq[ip[5:0]];
  assign out_full_i = full_q;

  acc8_cpu uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .prog_we_i(prog_we_i), .prog_addr_i(prog_addr_i), .prog_data_i(prog_data_i),
    .debug_i(debug_i), .step_i(step_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_pop_o(in_pop_o),
    .out_full_i(out_full_i), .out_push_o(out_push_o), .out_data_o(out_data_o),
    .pc_o(pc_o), .halted_o(halted_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // sample mid-cycle, apply queue bookkeeping just after the edge
  task automatic tick();
    bit p, q;
    logic [7:0] d;
    @(negedge clk);
    p = in_pop_o; q = out_push_o; d = out_data_o;
    @(posedge clk);
    #1;
    if (p) begin ip++; pop_cnt++; end
    if (q) begin
      if (on < 64) outq[on] = d;
      on++; push_cnt++;
    end
    if (rand_stall) begin
      avail  = ($urandom % 4) != 0;
      full_q = ($urandom % 4) == 0;
    end
  endtask

  task automatic put(logic [7:0] b);
    prog[pl[7:0]] = b;
    pl++;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 8'hF0;
    pl = 0;
  endtask

  // instruction-level model of the requirements
  task automatic ref_run();
    logic [7:0] m [32];
    logic [7:0] r, pc, w, o, nx;
    logic [4:0] a;
    logic [3:0] op;
    bit two, ind, done;
    int k, steps;
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    r = 0; pc = 0; k = 0; en = 0; ref_cyc = 0; ref_halt = 0; done = 0; steps = 0;
    while (!done && steps < 5000) begin
      steps++;
      w   = prog[pc];
      op  = w[7:4];
      two = !(op inside {4'h0, 4'h1, 4'hB, 4'hD, 4'hE, 4'hF});
      ind = w[3] && (op inside {[4'h2:4'h7]});
      o   = two ? prog[pc + 8'd1] : 8'h00;
      nx  = pc + (two ? 8'd2 : 8'd1);
      a   = o[4:0];
      if (ind) a = m[a][4:0];
      ref_cyc += (two ? 3 : 2) + (ind ? 1 : 0);
      case (op)
        4'h0: if (k >= in_n) done = 1; else begin r = inq[k]; k++; end
        4'h1: begin if (en < 64) expq[en] = r; en++; end
        4'h2: r = m[a];
        4'h3: m[a] = r;
        4'h4: r = r + m[a];
        4'h5: r = r - m[a];
        4'h6: begin m[a] = m[a] + 8'd1; r = m[a]; end
        4'h7: begin m[a] = m[a] - 8'd1; r = m[a]; end
        4'h8: nx = o;
        4'h9: if (r == 8'd0) nx = o;
        4'hA: if (r[7]) nx = o;
        4'hC: r = o;
        4'hF: begin done = 1; ref_halt = 1; end
        default: ;
      endcase
      pc = nx;
    end
  endtask

  task automatic reset_load();
    rst_ni = 1'b0;
    for (int i = 0; i < 256; i++) begin
      prog_we_i = 1'b1; prog_addr_i = i[7:0]; prog_data_i = prog[i];
      tick();
    end
    prog_we_i = 1'b0;
    tick();
    ip = 0; on = 0; pop_cnt = 0; push_cnt = 0;
    chk("R1", "pc in reset", pc_o, 0);
    chk("R1", "halted in reset", halted_o, 0);
    chk("R1", "queue strobes in reset", {in_pop_o, out_push_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic run_halt(int max, output int n);
    n = 0;
    while (!halted_o && n < max) begin
      tick();
      n++;
    end
  endtask

  task automatic compare_out(string req);
    chk(req, "output count", on, en);
    for (int i = 0; i < en && i < 64; i++)
      chk(req, $sformatf("output %0d", i), outq[i], expq[i]);
  endtask

  task automatic build_p1();
    clear_prog();
    put(8'hB0);                           // unused nibble, no-op
    put(8'hC0); put(8'h05);               // SET 5
    put(8'h30); put(8'h03);               // COPYTO 3
    put(8'h00);                           // INBOX
    put(8'h40); put(8'h03); put(8'h10);   // ADD 3, OUT
    put(8'h50); put(8'h03); put(8'h10);   // SUB 3, OUT
    put(8'h60); put(8'h03); put(8'h10);   // BUMP+ 3, OUT
    put(8'h70); put(8'h04); put(8'h10);   // BUMP- 4, OUT
    put(8'hC0); put(8'h04);               // SET 4
    put(8'h30); put(8'h07);               // COPYTO 7 (pointer)
    put(8'h00);                           // INBOX
    put(8'h38); put(8'h07);               // COPYTO [7]
    put(8'h20); put(8'h04); put(8'h10);   // COPYFROM 4, OUT
    put(8'h68); put(8'h07); put(8'h10);   // BUMP+ [7], OUT
    put(8'h48); put(8'h07); put(8'h10);   // ADD [7], OUT
    put(8'h58); put(8'h07); put(8'h10);   // SUB [7], OUT
    put(8'h78); put(8'h07); put(8'h10);   // BUMP- [7], OUT
    put(8'h28); put(8'h07); put(8'h10);   // COPYFROM [7], OUT
    put(8'h20); put(8'h1F); put(8'h10);   // untouched cell, OUT
    put(8'h20); put(8'h27); put(8'h10);   // operand 0x27 -> cell 7
    put(8'hF0);
  endtask

  task automatic build_p2();
    clear_prog();
    put(8'h00);                           // 00 INBOX
    put(8'h90); put(8'h0E);               // 01 JUMPZ 0E
    put(8'h30); put(8'h02);               // 03 COPYTO 2
    put(8'h00); put(8'h10);               // 05 INBOX, OUT
    put(8'h20); put(8'h02); put(8'h10);   // 07 COPYFROM 2, OUT
    put(8'hA0); put(8'h10);               // 0A JUMPN 10
    put(8'h80); put(8'h00);               // 0C JUMP 00
    put(8'hF0); put(8'hF0);               // 0E HALT
    put(8'hC0); put(8'h7F); put(8'h10);   // 10 SET 7F, OUT
    put(8'h80); put(8'h00);               // 13 JUMP 00
  endtask

  initial begin
    int n, pairs, pc_hold, pushes_hold;
    void'($urandom(32'd7341));

    // directed: P1 without stalls, exact cycle count
    build_p1();
    inq[0] = 8'h3C; inq[1] = 8'hFF; in_n = 2;
    ref_run();
    avail = 1; full_q = 0; rand_stall = 0;
    reset_load();
    chk("R1", "pc after reset release", pc_o, 0);
    run_halt(4000, n);
    chk("R12", "cycles to halt", n, ref_cyc);
    chk("R10", "halted after HALT", halted_o, 1);
    compare_out("R1 R2 R5 R6 R7 R8");

    // P1 with random data and random queue stalls
    for (int t = 0; t < 4; t++) begin
      inq[0] = 8'($urandom); inq[1] = 8'($urandom); in_n = 2;
      ref_run();
      rand_stall = 1;
      reset_load();
      run_halt(6000, n);
      rand_stall = 0; avail = 1; full_q = 0;
      chk("R10", "halted after HALT", halted_o, 1);
      compare_out("R3 R4 R5 R6 R7 R8");
    end

    // P2: branches with random pair streams
    build_p2();
    for (int t = 0; t < 6; t++) begin
      pairs = 1 + ($urandom % 6);
      for (int i = 0; i < pairs; i++) begin
        inq[2*i]   = 8'(1 + ($urandom % 255));
        inq[2*i+1] = 8'($urandom);
      end
      if (t == 0) inq[0] = 8'h80 | inq[0];
      if (t == 1) inq[0] = 8'h01;
      inq[2*pairs] = 8'h00;
      in_n = 2*pairs + 1;
      ref_run();
      rand_stall = (t != 0);
      reset_load();
      run_halt(8000, n);
      rand_stall = 0; avail = 1; full_q = 0;
      chk("R9", "halted at sentinel", halted_o, 1);
      compare_out("R9");
    end

    // single-step mode
    build_p1();
    inq[0] = 8'h11; inq[1] = 8'h92; in_n = 2;
    ref_run();
    avail = 1; full_q = 0; debug_i = 1;
    reset_load();
    repeat (10) tick();
    chk("R11", "pc held before first fetch", pc_o, 0);
    step_i = 1; tick(); step_i = 0;
    repeat (8) tick();
    chk("R11", "pc after one-byte step", pc_o, 1);
    step_i = 1; tick(); step_i = 0;
    repeat (8) tick();
    chk("R11", "pc after two-byte step", pc_o, 3);
    chk("R11", "no output while stepping", on, 0);
    debug_i = 0;
    run_halt(4000, n);
    compare_out("R11");

    // stalls on queues, then halt stickiness
    clear_prog();
    put(8'h00); put(8'h10); put(8'hF0);
    inq[0] = 8'h5A; in_n = 1;
    avail = 0; full_q = 0;
    reset_load();
    repeat (40) tick();
    chk("R3", "no pop while input empty", pop_cnt, 0);
    chk("R2 R3", "pc parked in INBOX", pc_o, 1);
    chk("R3", "not halted while waiting", halted_o, 0);
    avail = 1; full_q = 1;
    repeat (40) tick();
    chk("R3", "one pop when data arrives", pop_cnt, 1);
    chk("R4", "no push while output full", push_cnt, 0);
    chk("R2 R4", "pc parked in OUTBOX", pc_o, 2);
    full_q = 0;
    run_halt(100, n);
    chk("R4", "single push", on, 1);
    chk("R4", "pushed value", outq[0], 8'h5A);
    pc_hold = pc_o; pushes_hold = push_cnt;
    repeat (30) tick();
    chk("R10", "halted stays", halted_o, 1);
    chk("R10", "pc frozen after halt", pc_o, pc_hold);
    chk("R2 R10", "pc past one-byte HALT", pc_hold, 3);
    chk("R10", "no pushes after halt", push_cnt, pushes_hold);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog: actual %0d cycles expected fewer", 190000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule